// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Lockstep Start

This block drives several pulse-width-modulated outputs from one clock. Each channel owns a tick counter, a period setting and a high-time setting. A channel's output is high from the start of its period until the counter reaches the high-time setting. The last tick of every period is always low, so no channel can be held high all the time.

Software talks to the block through a single-cycle write port. Each write selects one of four actions: set a channel's period, set a channel's high time, stage a new set of run bits, or commit the staged run bits. Period and high-time writes go into a shadow copy. A channel picks them up only when its own period ends, so it never produces a malformed pulse, and other channels are not affected. Run bits do nothing until a commit write. One commit can therefore start several channels on the same clock edge. A channel that is stopped by a commit finishes the period it is in before going idle.

Top module: `pwm_lockstep`

## Requirements
- R1: After a synchronous active-low reset, every output is low, every channel is stopped, and all shadow, staged and committed settings are zero.
- R2: A write is accepted when `wr_en` is high. `wr_kind` 0 sets the period setting of channel `wr_ch` to `wr_data`. `wr_kind` 1 sets the high-time setting of channel `wr_ch`. `wr_kind` 2 stages run bits, with bit i of `wr_data` belonging to channel i. `wr_kind` 3 commits the staged run bits to all channels at once.
- R3: A running channel with active period setting P repeats a period of P+1 ticks, numbered 0 to P. Its output is high on tick t exactly when t is below the active high-time setting D and t is not P.
- R4: Tick P is always low, even when D is larger than P. For example, P=4 and D=9 gives four high ticks and then one low tick.
- R5: With P=0, the period is one tick long and a running channel's output stays low.
- R6: New period and high-time settings written to a channel are first used on tick 0 of that channel's next period. The running period continues unchanged, and the running periods of other channels are not disturbed.
- R7: Staging run bits without a commit leaves every output and every channel's run state unchanged.
- R8: A stopped channel whose committed run bit is set begins tick 0 on the second clock edge after the commit write is sampled, using its current shadow settings. All channels enabled by the same commit start on the same edge.
- R9: A running channel whose committed run bit is cleared completes its current period through tick P and then stops.
- R10: A stopped channel keeps its output low and its counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock shared by all channels |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request for this cycle |
| wr_kind | input | 2 | Action: 0 period, 1 high time, 2 stage run bits, 3 commit |
| wr_ch | input | CH_W (2) | Target channel for period and high-time writes |
| wr_data | input | CNT_W (32) | Tick count, or run-bit mask in the low NUM_CH bits |
| pwm_out | output | NUM_CH (4) | One PWM output per channel |

## Verification
A shadow setting latched at the wrong time shows up as a changed high-pulse width or period length. This appears within one period after the write: early if the setting was taken mid-period, late if it was missed at the boundary. A corrupted counter or a missing wrap shows as a period that is not P+1 ticks long, or as a high level on the last tick, in the same period the fault occurs. A wrong run state becomes visible within two cycles of a commit. It shows as channels that start out of alignment, start without a commit, or stop before their running period has finished.

// File: rtl/pwm_lockstep_pkg.sv
// Package: shared write-action encoding for the lockstep PWM block.
// Assumes: one action per write cycle; encoding is visible on the wr_kind port.
package pwm_lockstep_pkg;
    typedef enum logic [1:0] {
        WK_PERIOD = 2'd0,
        WK_HIGH   = 2'd1,
        WK_STAGE  = 2'd2,
        WK_COMMIT = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/pwm_cfg_bank.sv
// Module: pwm_cfg_bank
// Holds the per-channel shadow period and high-time settings, the staged
// run bits and the committed run bits.
// Assumes: wr_ch is in range when a period or high-time write targets a channel.
module pwm_cfg_bank
    import pwm_lockstep_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int CH_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_kind,
    input  logic [CH_W-1:0]               wr_ch,
    input  logic [CNT_W-1:0]              wr_data,
    output logic [NUM_CH-1:0][CNT_W-1:0]  sh_period,
    output logic [NUM_CH-1:0][CNT_W-1:0]  sh_high,
    output logic [NUM_CH-1:0]             run_commit
);
    logic [NUM_CH-1:0] run_stage;

    // Staged and committed run bits: staged by WK_STAGE, copied over by WK_COMMIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_stage  <= '0;
            run_commit <= '0;
        end else if (wr_en && wr_kind == WK_STAGE) begin
            run_stage  <= wr_data[NUM_CH-1:0];
        end else if (wr_en && wr_kind == WK_COMMIT) begin
            run_commit <= run_stage;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_shadow
        logic [CNT_W-1:0] period_q;
        logic [CNT_W-1:0] high_q;

        // Shadow settings of channel g, written only by writes addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                period_q <= '0;
                high_q   <= '0;
            end else if (wr_en && wr_ch == CH_W'(g)) begin
                if (wr_kind == WK_PERIOD) period_q <= wr_data;
                if (wr_kind == WK_HIGH)   high_q   <= wr_data;
            end
        end

        assign sh_period[g] = period_q;
        assign sh_high[g]   = high_q;
    end

    AST_COMMIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run_commit) |-> $past(wr_en && wr_kind == WK_COMMIT)); // R7
endmodule

// File: rtl/pwm_chan_core.sv
// Module: pwm_chan_core
// One PWM channel: a tick counter with active settings that are reloaded from
// the shadow copies only at a period boundary or at start-up.
// Assumes: shadow settings and the committed run bit come from registers.
module pwm_chan_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] sh_period,
    input  logic [CNT_W-1:0] sh_high,
    input  logic             run_commit,
    output logic             pwm_out
);
    logic             running;
    logic [CNT_W-1:0] tick;
    logic [CNT_W-1:0] act_period;
    logic [CNT_W-1:0] act_high;
    logic             last_tick;

    assign last_tick = running && (tick == act_period);

    // Counter and active settings: start, wrap with reload, or advance one tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running    <= 1'b0;
            tick       <= '0;
            act_period <= '0;
            act_high   <= '0;
        end else if (!running) begin
            if (run_commit) begin
                running    <= 1'b1;
                tick       <= '0;
                act_period <= sh_period;
                act_high   <= sh_high;
            end
        end else if (last_tick) begin
            running    <= run_commit;
            tick       <= '0;
            act_period <= sh_period;
            act_high   <= sh_high;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    // Output level: high below the high time, forced low on the last tick.
    always_comb pwm_out = running && (tick < act_high) && !last_tick;

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick != act_period) |=> (tick == $past(tick) + 1'b1)); // R3
    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick == act_period) |=> (tick == '0)); // R3
    AST_HOLD_SETTINGS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick != act_period) |=> ($stable(act_period) && $stable(act_high))); // R6
    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(tick == act_period)); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (tick == '0 && !pwm_out)); // R10
    AST_ZERO_PERIOD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (running && act_period == '0) |-> !pwm_out); // R5
endmodule

// File: rtl/pwm_lockstep.sv
// Module: pwm_lockstep (top)
// Multi-channel PWM: a shared configuration bank feeds one counter core per
// channel; run bits are committed to all channels by one write.
// Assumes: one write action per cycle on the write port.
module pwm_lockstep #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0][CNT_W-1:0] sh_period;
    logic [NUM_CH-1:0][CNT_W-1:0] sh_high;
    logic [NUM_CH-1:0]            run_commit;

    pwm_cfg_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_kind    (wr_kind),
        .wr_ch      (wr_ch),
        .wr_data    (wr_data),
        .sh_period  (sh_period),
        .sh_high    (sh_high),
        .run_commit (run_commit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pwm_chan_core #(.CNT_W(CNT_W)) u_core (
            .clk        (clk),
            .rst_n      (rst_n),
            .sh_period  (sh_period[c]),
            .sh_high    (sh_high[c]),
            .run_commit (run_commit[c]),
            .pwm_out    (pwm_out[c])
        );
    end
endmodule

// File: tb/pwm_lockstep_tb.sv
`timescale 1ns/1ps
module pwm_lockstep_tb;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'd0;
    logic [1:0]  wr_ch = 2'd0;
    logic [31:0] wr_data = '0;
    logic [NCH-1:0] pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state, computed from the requirements.
    bit          m_run [NCH];
    logic [31:0] m_tick[NCH];
    logic [31:0] m_per [NCH];
    logic [31:0] m_hi  [NCH];
    logic [31:0] m_shp [NCH];
    logic [31:0] m_shh [NCH];
    bit          m_stg [NCH];
    bit          m_com [NCH];

    pwm_lockstep u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_ch(wr_ch), .wr_data(wr_data), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    function automatic bit f_level(bit run, logic [31:0] t, logic [31:0] p, logic [31:0] d);
        return run && (t < d) && (t != p);
    endfunction

    task automatic m_reset();
        for (int i = 0; i < NCH; i++) begin
            m_run[i] = 0; m_tick[i] = 0; m_per[i] = 0; m_hi[i] = 0;
            m_shp[i] = 0; m_shh[i] = 0; m_stg[i] = 0; m_com[i] = 0;
        end
    endtask

    task automatic m_step(bit we, logic [1:0] k, int ch, logic [31:0] d);
        for (int i = 0; i < NCH; i++) begin
            if (!m_run[i]) begin
                if (m_com[i]) begin
                    m_run[i] = 1; m_tick[i] = 0; m_per[i] = m_shp[i]; m_hi[i] = m_shh[i];
                end
            end else if (m_tick[i] == m_per[i]) begin
                m_run[i] = m_com[i]; m_tick[i] = 0; m_per[i] = m_shp[i]; m_hi[i] = m_shh[i];
            end else begin
                m_tick[i] = m_tick[i] + 1;
            end
        end
        if (we) begin
            case (k)
                2'd0: m_shp[ch] = d;
                2'd1: m_shh[ch] = d;
                2'd2: for (int i = 0; i < NCH; i++) m_stg[i] = d[i];
                default: for (int i = 0; i < NCH; i++) m_com[i] = m_stg[i];
            endcase
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        logic [NCH-1:0] e;
        for (int i = 0; i < NCH; i++) e[i] = f_level(m_run[i], m_tick[i], m_per[i], m_hi[i]);
        check(tag, 32'(pwm_out), 32'(e));
    endtask

    // One clock cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(bit we, logic [1:0] k, int ch, logic [31:0] d, string tag);
        wr_en = we; wr_kind = k; wr_ch = 2'(ch); wr_data = d;
        @(posedge clk);
        #1;
        m_step(we, k, ch, d);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(0, 2'd0, 0, 32'd0, tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0005EED5));
        m_reset();
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs", 32'(pwm_out), 32'd0);
        idle(3, "R1");

        // R7: staged run bits with no commit change nothing.
        cyc(1, 2'd0, 0, 32'd3, "R2");
        cyc(1, 2'd1, 0, 32'd2, "R2");
        cyc(1, 2'd2, 0, 32'hF, "R7");
        idle(12, "R7");
        check("R7 no start without commit", 32'(pwm_out), 32'd0);

        // R8: lockstep start with distinct periods.
        cyc(1, 2'd0, 1, 32'd5, "R2");
        cyc(1, 2'd0, 2, 32'd7, "R2");
        cyc(1, 2'd0, 3, 32'd9, "R2");
        for (int i = 1; i < NCH; i++) cyc(1, 2'd1, i, 32'd2, "R2");
        cyc(1, 2'd3, 0, 32'd0, "R8");
        check("R8 one cycle after commit", 32'(pwm_out), 32'd0);
        idle(1, "R8");
        check("R8 aligned start", 32'(pwm_out), 32'hF);
        idle(30, "R3");

        // R4: high time beyond the period; R5: zero period; R6 mid-period writes.
        cyc(1, 2'd0, 1, 32'd4, "R6");
        cyc(1, 2'd1, 1, 32'd9, "R4");
        idle(25, "R4");
        cyc(1, 2'd0, 2, 32'd0, "R5");
        cyc(1, 2'd1, 2, 32'd5, "R5");
        idle(20, "R5");

        // R9: clear all run bits; channels finish their running period.
        cyc(1, 2'd0, 3, 32'd40, "R6");
        idle(12, "R6");
        cyc(1, 2'd2, 0, 32'h0, "R9");
        cyc(1, 2'd3, 0, 32'd0, "R9");
        idle(60, "R9");
        check("R10 all stopped low", 32'(pwm_out), 32'd0);

        // Random mix of writes and commits.
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 5) == 0) begin
                int kk;
                kk = $urandom_range(0, 9);
                if (kk < 4)      cyc(1, 2'd0, $urandom_range(0, 3), 32'($urandom_range(0, 10)), "R6");
                else if (kk < 7) cyc(1, 2'd1, $urandom_range(0, 3), 32'($urandom_range(0, 12)), "R3");
                else if (kk < 9) cyc(1, 2'd2, 0, 32'($urandom_range(0, 15)), "R7");
                else             cyc(1, 2'd3, 0, 32'd0, "R8");
            end else begin
                cyc(0, 2'd0, 0, 32'd0, "R3");
            end
        end

        // Stop everything and confirm idle level.
        cyc(1, 2'd2, 0, 32'h0, "R9");
        cyc(1, 2'd3, 0, 32'd0, "R9");
        idle(40, "R10");
        check("R10 final idle", 32'(pwm_out), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule